// File: doc/BRIEF.md
# Reservation Snoop Monitor

This block keeps the single load-reserve / store-conditional reservation of one processor in a snooping multiprocessor that uses MESI coherency. When the core executes a load-reserve, the block latches the cache-block address and marks the reservation valid. The block then watches every transaction that other bus masters place on the snoop port. For the transfers that hand ownership of the reserved block to another master, it drops the reservation. For reads of the reserved block, it drives the shared response so that the reading cache cannot fill the line Exclusive and later modify it without a bus transaction.

A store-conditional is checked against the reservation at the cycle it is issued. A store-conditional that fails completes at once. A store-conditional that succeeds raises a request for its flush-atomic write and does not report completion until the memory system acknowledges that the write is globally performed. The reservation valid flag and the block address are brought out so that an outer cache level can keep a copy of the reservation and filter on it.

Top module: `rsv_snoop_mon`

## Requirements
- R1: After reset, rsv_valid, rsv_addr, wfa_req, sc_done, sc_ok, snp_shared and snp_err are all 0.
- R2: A load-reserve (lr_valid) sets rsv_valid and loads rsv_addr with lr_addr, low 5 bits cleared (32-byte blocks), from the next cycle on. A later load-reserve replaces the earlier address.
- R3: snp_shared is 1 in the same cycle as a snoop with snp_valid=1 and snp_type read (3'd1) or read-atomic (3'd2) whose block equals the valid reserved block. For every other type, for another block, or with no reservation, it is 0. No cache state is consulted.
- R4: A matching snoop of type read-with-intent-to-modify (3'd3), its atomic form (3'd4) or kill-block (3'd5) clears rsv_valid from the next cycle.
- R5: Addresses are compared on bits [31:5] only. Snoops of none (3'd0), read, read-atomic or plain write (3'd7), and any snoop to another block, leave the reservation unchanged.
- R6: A matching write-with-kill snoop (3'd6) while the reservation is valid drives snp_err to 1 in the same cycle and leaves the reservation in place.
- R7: When a load-reserve and a cancelling snoop fall in the same cycle, the reservation ends up valid with the new load-reserve address.
- R8: A store-conditional (sc_valid) succeeds only if rsv_valid is 1 and its block matches. On success, wfa_req is 1 from the next cycle. On failure, sc_done=1 and sc_ok=0 for exactly the next cycle, and wfa_req stays 0.
- R9: An accepted store-conditional clears the reservation from the next cycle, whether it succeeds or fails.
- R10: After a successful store-conditional, wfa_req holds and sc_done stays 0 until gp_ack is sampled high. In the following cycle, sc_done=1 and sc_ok=1 for one cycle and wfa_req falls.
- R11: While wfa_req is 1, sc_valid is ignored and the reservation is untouched. gp_ack while no write is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lr_valid | input | 1 | Core executes a load-reserve |
| lr_addr | input | 32 | Load-reserve byte address |
| sc_valid | input | 1 | Core issues a store-conditional |
| sc_addr | input | 32 | Store-conditional byte address |
| gp_ack | input | 1 | Flush-atomic write globally performed |
| snp_valid | input | 1 | Snooped transaction from another master |
| snp_type | input | 3 | Snooped transfer type code |
| snp_addr | input | 32 | Snooped byte address |
| snp_shared | output | 1 | Shared response for the snooped read |
| snp_err | output | 1 | Write-with-kill hit a held reservation |
| rsv_valid | output | 1 | Reservation held |
| rsv_addr | output | 32 | Reserved block address |
| wfa_req | output | 1 | Store-conditional write pending at memory |
| sc_done | output | 1 | Store-conditional completes this cycle |
| sc_ok | output | 1 | Store-conditional result, valid with sc_done |

## Verification
The bench snoops with addresses that differ from the reserved one only in the low five bits. A design that compared full byte addresses would then miss the shared response and fail to cancel. It sends each ownership-transferring type on its own and pairs one with a load-reserve in the same cycle, where a design with the wrong priority would lose the new reservation. It holds the memory acknowledge back for several cycles to catch any design that reports success early or drops the pending write. It also issues a second store-conditional and a stray acknowledge at points where a design that failed to ignore them would clear the reservation or report a false completion.

// File: rtl/rsv_snoop_pkg.sv
package rsv_snoop_pkg;

  typedef enum logic [2:0] {
    SNP_NONE      = 3'd0,
    SNP_READ      = 3'd1,
    SNP_READ_ATOM = 3'd2,
    SNP_RWITM     = 3'd3,
    SNP_RWITM_ATM = 3'd4,
    SNP_KILL      = 3'd5,
    SNP_WR_KILL   = 3'd6,
    SNP_WRITE     = 3'd7
  } snp_kind_t;

  typedef enum logic [1:0] {
    SC_IDLE      = 2'd0,
    SC_WAIT      = 2'd1,
    SC_DONE_OK   = 2'd2,
    SC_DONE_FAIL = 2'd3
  } sc_state_t;

endpackage

// File: rtl/rsv_hold.sv
module rsv_hold #(
  parameter int AW = 32,
  parameter int BO = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic [AW-1:0] set_addr_i,
  input  logic          clr_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o
);
  localparam int BW = AW - BO;
  localparam logic [AW-1:0] BLK_MASK = {{BW{1'b1}}, {BO{1'b0}}};

  logic          valid_q, valid_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          upd_valid, upd_addr;

  always_comb begin
    valid_d   = valid_q;
    addr_d    = addr_q;
    upd_valid = 1'b0;
    upd_addr  = 1'b0;
    if (set_i) begin
      valid_d   = 1'b1;
      addr_d    = set_addr_i & BLK_MASK;
      upd_valid = 1'b1;
      upd_addr  = 1'b1;
    end else if (clr_i) begin
      valid_d   = 1'b0;
      upd_valid = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (upd_valid) begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (upd_addr) begin
      addr_q <= addr_d;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;

  AST_SET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> valid_o && (addr_o == ($past(set_addr_i) & BLK_MASK))); // R2
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !valid_o); // R4
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_o & ~BLK_MASK) == '0); // R2

endmodule

// File: rtl/rsv_snoop_cmp.sv
module rsv_snoop_cmp
  import rsv_snoop_pkg::*;
#(
  parameter int AW = 32,
  parameter int BO = 5
) (
  input  logic          snp_valid_i,
  input  snp_kind_t     snp_kind_i,
  input  logic [AW-1:0] snp_addr_i,
  input  logic          rsv_valid_i,
  input  logic [AW-1:0] rsv_addr_i,
  output logic          shared_o,
  output logic          cancel_o,
  output logic          err_o
);
  localparam int BW = AW - BO;
  localparam logic [AW-1:0] BLK_MASK = {{BW{1'b1}}, {BO{1'b0}}};

  logic hit;
  logic is_read, is_xfer, is_wkill;

  always_comb begin
    hit      = snp_valid_i && rsv_valid_i &&
               (((snp_addr_i ^ rsv_addr_i) & BLK_MASK) == '0);
    is_read  = 1'b0;
    is_xfer  = 1'b0;
    is_wkill = 1'b0;
    unique case (snp_kind_i)
      SNP_READ, SNP_READ_ATOM:           is_read  = 1'b1;
      SNP_RWITM, SNP_RWITM_ATM, SNP_KILL: is_xfer = 1'b1;
      SNP_WR_KILL:                       is_wkill = 1'b1;
      default: ;
    endcase
    shared_o = hit && is_read;
    cancel_o = hit && is_xfer;
    err_o    = hit && is_wkill;
  end

endmodule

// File: rtl/rsv_sc_gate.sv
module rsv_sc_gate
  import rsv_snoop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sc_valid_i,
  input  logic sc_hit_i,
  input  logic ack_i,
  output logic take_o,
  output logic wfa_req_o,
  output logic done_o,
  output logic ok_o
);
  sc_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    take_o  = 1'b0;
    unique case (state_q)
      SC_WAIT: begin
        if (ack_i) state_d = SC_DONE_OK;
      end
      default: begin
        take_o = sc_valid_i;
        if (sc_valid_i) state_d = sc_hit_i ? SC_WAIT : SC_DONE_FAIL;
        else            state_d = SC_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign wfa_req_o = (state_q == SC_WAIT);
  assign done_o    = (state_q == SC_DONE_OK) || (state_q == SC_DONE_FAIL);
  assign ok_o      = (state_q == SC_DONE_OK);

  AST_OK_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ok_o) |-> $past(wfa_req_o && ack_i)); // R10
  AST_WFA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wfa_req_o && !ack_i) |=> (wfa_req_o && !done_o)); // R10
  AST_MISS_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !sc_hit_i) |=> (done_o && !ok_o && !wfa_req_o)); // R8
  AST_HIT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && sc_hit_i) |=> (wfa_req_o && !done_o)); // R8

endmodule

// File: rtl/rsv_snoop_mon.sv
module rsv_snoop_mon
  import rsv_snoop_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lr_valid,
  input  logic [AW-1:0] lr_addr,
  input  logic          sc_valid,
  input  logic [AW-1:0] sc_addr,
  input  logic          gp_ack,
  input  logic          snp_valid,
  input  logic [2:0]    snp_type,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_shared,
  output logic          snp_err,
  output logic          rsv_valid,
  output logic [AW-1:0] rsv_addr,
  output logic          wfa_req,
  output logic          sc_done,
  output logic          sc_ok
);
  localparam int BO = $clog2(BLK_BYTES);
  localparam int BW = AW - BO;
  localparam logic [AW-1:0] BLK_MASK = {{BW{1'b1}}, {BO{1'b0}}};

  logic snp_cancel;
  logic sc_take;
  logic sc_hit;
  logic rsv_clr;

  rsv_hold #(.AW(AW), .BO(BO)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (lr_valid),
    .set_addr_i (lr_addr),
    .clr_i      (rsv_clr),
    .valid_o    (rsv_valid),
    .addr_o     (rsv_addr)
  );

  rsv_snoop_cmp #(.AW(AW), .BO(BO)) u_cmp (
    .snp_valid_i (snp_valid),
    .snp_kind_i  (snp_kind_t'(snp_type)),
    .snp_addr_i  (snp_addr),
    .rsv_valid_i (rsv_valid),
    .rsv_addr_i  (rsv_addr),
    .shared_o    (snp_shared),
    .cancel_o    (snp_cancel),
    .err_o       (snp_err)
  );

  assign sc_hit  = rsv_valid && (((sc_addr ^ rsv_addr) & BLK_MASK) == '0);
  assign rsv_clr = snp_cancel || sc_take;

  rsv_sc_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .sc_valid_i (sc_valid),
    .sc_hit_i   (sc_hit),
    .ack_i      (gp_ack),
    .take_o     (sc_take),
    .wfa_req_o  (wfa_req),
    .done_o     (sc_done),
    .ok_o       (sc_ok)
  );

  AST_SHARED_NEEDS_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared |-> (rsv_valid && snp_valid)); // R3
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({snp_shared, snp_cancel, snp_err})); // R5
  AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_take && !lr_valid) |=> !rsv_valid); // R9
  AST_WKILL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_err && !lr_valid && !sc_take) |=> rsv_valid); // R6
  AST_LR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_valid && snp_cancel) |=> rsv_valid); // R7
  AST_BUSY_IGNORES_SC: assert property (@(posedge clk) disable iff (!rst_n)
    (wfa_req && rsv_valid && !lr_valid && !snp_cancel) |=> rsv_valid); // R11

endmodule

// File: tb/rsv_snoop_mon_test.sv
`timescale 1ns/1ps
module rsv_snoop_mon_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lr_valid, sc_valid, gp_ack, snp_valid;
  logic [31:0] lr_addr, sc_addr, snp_addr;
  logic [2:0]  snp_type;
  logic        snp_shared, snp_err, rsv_valid, wfa_req, sc_done, sc_ok;
  logic [31:0] rsv_addr;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rsv_snoop_mon uut (
    .clk(clk), .rst_n(rst_n),
    .lr_valid(lr_valid), .lr_addr(lr_addr),
    .sc_valid(sc_valid), .sc_addr(sc_addr), .gp_ack(gp_ack),
    .snp_valid(snp_valid), .snp_type(snp_type), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_err(snp_err),
    .rsv_valid(rsv_valid), .rsv_addr(rsv_addr),
    .wfa_req(wfa_req), .sc_done(sc_done), .sc_ok(sc_ok)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic quiet();
    lr_valid = 0; lr_addr = 0; sc_valid = 0; sc_addr = 0; gp_ack = 0;
    snp_valid = 0; snp_type = 0; snp_addr = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reserve(input logic [31:0] a);
    lr_valid = 1; lr_addr = a;
    tick();
    quiet();
  endtask

  task automatic snoop(input logic [2:0] t, input logic [31:0] a);
    snp_valid = 1; snp_type = t; snp_addr = a;
    #1;
  endtask

  task automatic t_reset();
    chk("R1", "rsv_valid", {31'd0, rsv_valid}, 32'd0);
    chk("R1", "rsv_addr", rsv_addr, 32'd0);
    chk("R1", "wfa_req", {31'd0, wfa_req}, 32'd0);
    chk("R1", "sc_done", {31'd0, sc_done}, 32'd0);
    chk("R1", "sc_ok", {31'd0, sc_ok}, 32'd0);
    snoop(3'd1, 32'h0);
    chk("R3", "shared without reservation", {31'd0, snp_shared}, 32'd0);
    chk("R1", "snp_err", {31'd0, snp_err}, 32'd0);
    quiet();
  endtask

  task automatic t_reserve();
    reserve(32'h1000_0047);
    chk("R2", "valid after lr", {31'd0, rsv_valid}, 32'd1);
    chk("R2", "block addr", rsv_addr, 32'h1000_0040);
    reserve(32'h2000_01FF);
    chk("R2", "replaced addr", rsv_addr, 32'h2000_01E0);
  endtask

  task automatic t_shared();
    reserve(32'h3000_0100);
    snoop(3'd1, 32'h3000_011F);
    chk("R3", "read shared", {31'd0, snp_shared}, 32'd1);
    snoop(3'd2, 32'h3000_0104);
    chk("R3", "read-atomic shared", {31'd0, snp_shared}, 32'd1);
    snoop(3'd1, 32'h3000_0120);
    chk("R3", "other block read", {31'd0, snp_shared}, 32'd0);
    snoop(3'd7, 32'h3000_0100);
    chk("R3", "write not shared", {31'd0, snp_shared}, 32'd0);
    tick();
    chk("R5", "write keeps rsv", {31'd0, rsv_valid}, 32'd1);
    snoop(3'd1, 32'h3000_0100);
    tick();
    snoop(3'd0, 32'h3000_0100);
    tick();
    chk("R5", "read/none keep rsv", {31'd0, rsv_valid}, 32'd1);
    snoop(3'd3, 32'h3000_0140);
    tick();
    chk("R5", "rwitm other block keeps", {31'd0, rsv_valid}, 32'd1);
    quiet();
  endtask

  task automatic t_cancel();
    for (int k = 3; k <= 5; k++) begin
      reserve(32'h4000_0200);
      snoop(k[2:0], 32'h4000_021C);
      chk("R4", "no shared on xfer", {31'd0, snp_shared}, 32'd0);
      tick();
      quiet();
      chk("R4", $sformatf("cancel type %0d", k), {31'd0, rsv_valid}, 32'd0);
    end
  endtask

  task automatic t_wkill();
    reserve(32'h5000_0300);
    snoop(3'd6, 32'h5000_0310);
    chk("R6", "err on match", {31'd0, snp_err}, 32'd1);
    tick();
    quiet();
    chk("R6", "rsv kept", {31'd0, rsv_valid}, 32'd1);
    snoop(3'd6, 32'h5000_0400);
    chk("R6", "no err other block", {31'd0, snp_err}, 32'd0);
    quiet();
  endtask

  task automatic t_race();
    reserve(32'h6000_0000);
    lr_valid = 1; lr_addr = 32'h6100_0020;
    snp_valid = 1; snp_type = 3'd3; snp_addr = 32'h6000_0000;
    tick();
    quiet();
    chk("R7", "lr wins valid", {31'd0, rsv_valid}, 32'd1);
    chk("R7", "lr wins addr", rsv_addr, 32'h6100_0020);
  endtask

  task automatic t_sc_fail();
    reserve(32'h7000_0000);
    sc_valid = 1; sc_addr = 32'h7000_0020;
    tick();
    quiet();
    chk("R8", "fail done", {31'd0, sc_done}, 32'd1);
    chk("R8", "fail ok", {31'd0, sc_ok}, 32'd0);
    chk("R8", "fail no wfa", {31'd0, wfa_req}, 32'd0);
    chk("R9", "fail clears rsv", {31'd0, rsv_valid}, 32'd0);
    tick();
    chk("R8", "done one cycle", {31'd0, sc_done}, 32'd0);
    sc_valid = 1; sc_addr = 32'h7000_0000;
    tick();
    quiet();
    chk("R8", "no rsv fails", {31'd0, sc_done & ~sc_ok & ~wfa_req}, 32'd1);
    tick();
  endtask

  task automatic t_sc_ok();
    reserve(32'h8000_0080);
    sc_valid = 1; sc_addr = 32'h8000_009C;
    tick();
    quiet();
    chk("R8", "wfa raised", {31'd0, wfa_req}, 32'd1);
    chk("R9", "success clears rsv", {31'd0, rsv_valid}, 32'd0);
    chk("R10", "no early done", {31'd0, sc_done}, 32'd0);
    reserve(32'h8800_0000);
    sc_valid = 1; sc_addr = 32'h8800_0000;
    tick();
    quiet();
    chk("R11", "sc while busy ignored", {31'd0, rsv_valid}, 32'd1);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R10", "wfa held", {31'd0, wfa_req}, 32'd1);
      chk("R10", "done held off", {31'd0, sc_done}, 32'd0);
    end
    gp_ack = 1;
    tick();
    quiet();
    chk("R10", "done after ack", {31'd0, sc_done}, 32'd1);
    chk("R10", "ok after ack", {31'd0, sc_ok}, 32'd1);
    chk("R10", "wfa dropped", {31'd0, wfa_req}, 32'd0);
    tick();
    chk("R10", "done one cycle", {31'd0, sc_done}, 32'd0);
    gp_ack = 1;
    tick();
    quiet();
    chk("R11", "stray ack no done", {31'd0, sc_done}, 32'd0);
    chk("R11", "stray ack no wfa", {31'd0, wfa_req}, 32'd0);
    chk("R11", "stray ack keeps rsv", {31'd0, rsv_valid}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    quiet();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_reserve();
    t_shared();
    t_cancel();
    t_wkill();
    t_race();
    t_sc_fail();
    t_sc_ok();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule